// File: doc/BRIEF.md
# Dual-Mode Elastic Sample Buffer

This block is a small first-in first-out store placed between two stream-processing stages. The writing and reading stages may share one clock or run on clocks that are not related. Each side has its own clock and its own active-low reset. Write and read pointers pass between the two clock domains as Gray code through two-flop synchronisers.

A static configuration input selects one of two modes. In handshaking mode, a full flag on the write side and an empty flag on the read side tell the neighbouring stages when to stall. Continuous mode is meant for a link across a small clock-rate mismatch, and there the buffer never asks either side to wait. A read request that finds nothing stored repeats the last sample delivered. A write that arrives while every slot is occupied is dropped. Both flags stay low in this mode, so the sample stream keeps its pace.

Top module: `elastic_sample_buffer`

## Requirements
- R1: While reset is applied and right after it, `rd_data` is zero, `wr_full` is low, and in handshaking mode (`cont_mode` = 0) `rd_empty` is high.
- R2: Samples are delivered in the order in which they were accepted, and none is lost or duplicated while the buffer is neither empty nor full.
- R3: In handshaking mode, `rd_empty` goes high on the read-clock edge that removes the last stored sample, and goes low no more than three read-clock edges after a write is accepted.
- R4: In handshaking mode, `wr_full` is high while 2**ADDR_W samples are stored. A write offered in that state is ignored, and the stored samples stay unchanged.
- R5: In handshaking mode, a read request while `rd_empty` is high removes nothing and leaves `rd_data` unchanged.
- R6: In continuous mode (`cont_mode` = 1), `wr_full` and `rd_empty` stay low at all times.
- R7: In continuous mode, a read request that finds no stored sample makes `rd_data` repeat the last sample read. Once new samples arrive, reading resumes with them.
- R8: In continuous mode, a write that arrives while 2**ADDR_W samples are stored is discarded. The stored samples are then read out unchanged and in order.
- R9: An accepted read updates `rd_data` on the same read-clock edge that takes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low, asserted asynchronously |
| wr_valid | input | 1 | Write-side sample present |
| wr_data | input | DATA_W | Sample to store |
| wr_full | output | 1 | Handshaking mode only: no free slot |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low, asserted asynchronously |
| rd_req | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output sample |
| rd_empty | output | 1 | Handshaking mode only: nothing stored |
| cont_mode | input | 1 | 0 = handshaking, 1 = continuous; change only while both sides are in reset |

## Verification
The checks that run on every cycle cover four things. Both flags must be silent in continuous mode. Each pointer may change by only one Gray bit per step. A refused write must leave the write pointer where it was, and a request on an empty buffer must leave `rd_data` unchanged. An accepted read must always move the read pointer. Only the bench scenarios can show that the data comes out in the right order, and which sample is repeated or dropped at the edges. They also show that the flags settle after the pointers cross between the clock domains, which takes several cycles.

// File: rtl/esb_pkg.sv
package esb_pkg;
  typedef enum logic {
    MODE_HANDSHAKE  = 1'b0,
    MODE_CONTINUOUS = 1'b1
  } esb_mode_e;
endpackage

// File: rtl/esb_sync2.sv
module esb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/esb_wr_ctrl.sv
module esb_wr_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [ADDR_W:0] rd_gray_sync,
  output logic            wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0] gray_q,
  output logic            full
);
  logic [ADDR_W:0] bin_q, bin_d, gray_d;

  // full when the write pointer is one lap ahead of the read pointer
  assign full  = (gray_q == {~rd_gray_sync[ADDR_W:ADDR_W-1], rd_gray_sync[ADDR_W-2:0]});
  assign wr_en = valid && !full;
  assign addr  = bin_q[ADDR_W-1:0];

  always_comb begin
    bin_d  = bin_q + {{ADDR_W{1'b0}}, wr_en};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (wr_en) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end
endmodule

// File: rtl/esb_rd_ctrl.sv
module esb_rd_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [ADDR_W:0] wr_gray_sync,
  output logic            rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0] gray_q,
  output logic            empty
);
  logic [ADDR_W:0] bin_q, bin_d, gray_d;

  assign empty = (gray_q == wr_gray_sync);
  assign rd_en = req && !empty;
  assign addr  = bin_q[ADDR_W-1:0];

  always_comb begin
    bin_d  = bin_q + {{ADDR_W{1'b0}}, rd_en};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (rd_en) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end
endmodule

// File: rtl/elastic_sample_buffer.sv
module elastic_sample_buffer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty,
  input  logic              cont_mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic wr_rst_q, rd_rst_q;
  logic wr_en, rd_en, full_int, empty_int, is_cont;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_d;

  assign is_cont = (cont_mode == esb_pkg::MODE_CONTINUOUS);

  // reset asserted at once, released on each side's own clock
  esb_sync2 #(.W(1)) u_wr_rst (.clk(wr_clk), .rst_n(wr_rst_n), .d(1'b1), .q(wr_rst_q));
  esb_sync2 #(.W(1)) u_rd_rst (.clk(rd_clk), .rst_n(rd_rst_n), .d(1'b1), .q(rd_rst_q));

  // pointer crossings
  esb_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rd_rst_q), .d(wr_gray), .q(wr_gray_s));
  esb_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wr_rst_q), .d(rd_gray), .q(rd_gray_s));

  esb_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_q), .valid(wr_valid), .rd_gray_sync(rd_gray_s),
    .wr_en(wr_en), .addr(wr_addr), .gray_q(wr_gray), .full(full_int)
  );

  esb_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_q), .req(rd_req), .wr_gray_sync(wr_gray_s),
    .rd_en(rd_en), .addr(rd_addr), .gray_q(rd_gray), .empty(empty_int)
  );

  // storage: no reset, written under its clock enable
  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // holding rd_data when nothing is popped gives the repeat in continuous mode
  always_comb begin
    rdata_d = rd_en ? mem[rd_addr] : rd_data;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_q) begin
    if (!rd_rst_q) rd_data <= '0;
    else           rd_data <= rdata_d;
  end

  // flags go out only in handshaking mode
  assign wr_full  = full_int  && !is_cont;
  assign rd_empty = empty_int && !is_cont;
endmodule

// File: rtl/esb_chk.sv
module esb_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_q,
  input logic              rd_rst_q,
  input logic              cont_mode,
  input logic              rd_req,
  input logic              rd_empty,
  input logic              wr_full,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W:0]   wr_gray,
  input logic [ADDR_W:0]   rd_gray,
  input logic              empty_int,
  input logic              full_int
);
  // R6
  cont_empty_low_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    cont_mode |-> !rd_empty);

  // R6
  cont_full_low_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_q)
    cont_mode |-> !wr_full);

  // R5
  hold_on_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    (rd_req && empty_int) |=> $stable(rd_data));

  // R4
  no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_q)
    full_int |=> $stable(wr_gray));

  // R2
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_q)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  // R2
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

  // R9
  pop_advances_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_q)
    (rd_req && !empty_int) |=> (rd_gray != $past(rd_gray)));
endmodule

bind elastic_sample_buffer esb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_q(wr_rst_q), .rd_rst_q(rd_rst_q),
  .cont_mode(cont_mode), .rd_req(rd_req), .rd_empty(rd_empty), .wr_full(wr_full),
  .rd_data(rd_data), .wr_gray(wr_gray), .rd_gray(rd_gray),
  .empty_int(empty_int), .full_int(full_int)
);

// File: tb/elastic_sample_buffer_tb_top.sv
module elastic_sample_buffer_tb_top;
  localparam int DW = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_req = 1'b0, cont_mode = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  elastic_sample_buffer #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(clk), .rd_rst_n(rst_n), .rd_req(rd_req),
    .rd_data(rd_data), .rd_empty(rd_empty), .cont_mode(cont_mode)
  );

  // row: {is_read, flag, data[7:0], req[3:0]}
  // write rows: flag = expected wr_full; read rows: data = expected rd_data, flag = expected rd_empty
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h11, 4'd3},
    {1'b1, 1'b1, 8'h11, 4'd3},
    {1'b0, 1'b0, 8'h21, 4'd2},
    {1'b0, 1'b0, 8'h22, 4'd2},
    {1'b0, 1'b0, 8'h23, 4'd2},
    {1'b0, 1'b1, 8'h24, 4'd4},
    {1'b0, 1'b1, 8'h99, 4'd4},
    {1'b1, 1'b0, 8'h21, 4'd4},
    {1'b1, 1'b0, 8'h22, 4'd2},
    {1'b1, 1'b0, 8'h23, 4'd2},
    {1'b1, 1'b1, 8'h24, 4'd3},
    {1'b1, 1'b1, 8'h24, 4'd5},
    {1'b1, 1'b1, 8'h24, 4'd5}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
    settle();
  endtask

  task automatic do_read();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic apply_reset(input logic mode);
    @(negedge clk); rst_n = 1'b0; cont_mode = mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values in handshaking mode
    check("R1 rd_data", rd_data, 0);
    check("R1 rd_empty", rd_empty, 1);
    check("R1 wr_full", wr_full, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd_empty after release", rd_empty, 1);

    // R9: an accepted read shows the sample right after the edge that takes it
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h5A;
    @(negedge clk); wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R3: within three edges of the write, rd_empty is low
    check("R3 empty clears", rd_empty, 0);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    check("R9 data after one edge", rd_data, 8'h5A);
    check("R3 empty on last pop", rd_empty, 1);
    settle();

    // table walk in handshaking mode, depth 4 (R2 R3 R4 R5)
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row %0d", v[3:0], i);
      if (v[13]) begin
        do_read();
        check({tag, " data"}, rd_data, v[11:4]);
        check({tag, " empty"}, rd_empty, v[12]);
        settle();
      end else begin
        do_write(v[11:4]);
        check({tag, " full"}, wr_full, v[12]);
      end
    end
    check("R4 full clear after drain", wr_full, 0);

    // continuous mode
    apply_reset(1'b1);
    check("R6 empty low after reset", rd_empty, 0);
    check("R1 rd_data zero", rd_data, 0);
    // R7: request on nothing stored repeats last (zero after reset)
    do_read();
    check("R7 repeat at start", rd_data, 0);
    for (int k = 0; k < 5; k++) do_write(8'h31 + k[7:0]);
    check("R6 full low when stored max", wr_full, 0);
    for (int k = 0; k < 4; k++) begin
      do_read();
      // R8: the four kept samples come out in order, 8'h35 was dropped
      check("R8 kept order", rd_data, 8'h31 + k);
      check("R6 empty low", rd_empty, 0);
      settle();
    end
    do_read();
    check("R7 repeat last", rd_data, 8'h34);
    do_read();
    check("R7 repeat again", rd_data, 8'h34);
    check("R6 empty low while drained", rd_empty, 0);
    settle();
    do_write(8'h41);
    do_read();
    check("R7 resume with new sample", rd_data, 8'h41);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule